// File: doc/BRIEF.md
# Bidirectional Saturating Barrel Shifter

This block shifts or rotates a 64-bit or 32-bit operand by a signed count. A positive count moves the bits in the direction the mode names. A negative count moves them the other way by the magnitude of the count. Arithmetic variants fill from the sign and logical variants fill with zeros. Two saturating variants clamp any left shift whose exact value does not fit in the selected width. Rotates take the count modulo the width.

The operation is accepted with a valid strobe and its result appears one clock later from a register. A one-cycle overflow pulse marks every clamped result, so a status bit elsewhere can collect it and keep it. In 32-bit mode only the low half of the source is used, and the upper half of the result is zero.

Top module: `bidir_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `ovf` and `result` are cleared to zero on that edge, whatever the other inputs are.
- R2: An operation presented with `in_valid` high appears on `result` with `out_valid` high one clock later. A cycle with `in_valid` low drops `out_valid` and leaves `result` unchanged.
- R3: Modes are encoded as follows: 0 arithmetic-left, 1 logical-left, 2 arithmetic-right, 3 logical-right, 4 saturating arithmetic-left, 5 saturating arithmetic-right, 6 rotate-left, 7 rotate-right. `amt` is two's complement. Modes 0 and 1 with a count of zero or more shift left and fill with zeros.
- R4: Modes 0, 1 and 4 with a negative count shift right by the count's magnitude. Modes 0 and 4 copy the sign bit in, and mode 1 fills with zeros. A magnitude equal to the width leaves only sign bits (modes 0 and 4) or zero (mode 1).
- R5: Modes 2 and 5 with a count of zero or more shift right and copy the sign bit in. Mode 3 shifts right and fills with zeros. A count of at least the width gives all sign bits (modes 2 and 5) or zero (mode 3).
- R6: Modes 2 and 3 with a negative count shift left by the count's magnitude and fill with zeros. A magnitude of at least the width gives zero.
- R7: Modes 4 (count of zero or more) and 5 (negative count) shift left by the magnitude. If the exact result fits in the selected signed width, it is returned unchanged. Otherwise the result is the most positive value of that width for a non-negative source, or the most negative value for a negative source.
- R8: A positive source whose significant bits all leave the word under a saturating left shift gives the most positive value. A zero source never saturates and gives zero.
- R9: Rotates use the count modulo the width, including a negative count. A reduced count of zero returns the source unchanged. Rotate-right by k equals rotate-left by the width minus k.
- R10: `wide`=1 selects 64-bit operation and `wide`=0 selects 32-bit. In 32-bit mode `src[63:32]` is ignored and `result[63:32]` is zero.
- R11: `ovf` is high for exactly the one cycle in which a clamped result (R7, R8) is presented. It is low for every other result and whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| src | input | 64 | Source operand |
| amt | input | 7 | Signed shift or rotate count |
| mode | input | 3 | Operation select (encoding in R3) |
| wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Registered result |
| ovf | output | 1 | Saturation pulse aligned with the result |

## Verification
The bench uses counts of exactly the width and beyond it, such as -64 and 40. A design that reverses the shift in one step by the magnitude would get these wrong: its logical result would keep bits, or its arithmetic result would not be all sign bits. Saturation is probed on both sides of the fit boundary for positive and negative sources, with a sign flip at count 63, with every bit shifted out, and with a zero source. A wrong compare against the original sign would either clamp legal values or pass wrapped ones. Rotates are checked with counts of zero, the full width and negative values, and 32-bit mode is run with garbage in the upper source half. A leaky mask or a wrong modulus would show up in the result.

// File: rtl/bshf_pkg.sv
// Shared types for the bidirectional shifter: operation codes and the
// decoded control word passed from the decoder to the datapath.
package bshf_pkg;

    typedef enum logic [2:0] {
        MODE_ASL     = 3'd0,
        MODE_LSL     = 3'd1,
        MODE_ASR     = 3'd2,
        MODE_LSR     = 3'd3,
        MODE_ASL_SAT = 3'd4,
        MODE_ASR_SAT = 3'd5,
        MODE_ROL     = 3'd6,
        MODE_ROR     = 3'd7
    } bshf_mode_e;

    typedef struct packed {
        logic go_left;    // effective direction after count sign
        logic arith;      // sign fill / sign extension
        logic sat_en;     // saturating left shift active
        logic rotate;     // rotate family
        logic rot_right;  // rotate direction
    } bshf_ctrl_t;

endpackage

// File: rtl/bshf_decode.sv
// Decodes mode and signed count into an effective direction, fill kind and
// count magnitude. Assumes a two's complement count; the most negative count
// yields a magnitude equal to 2^(AMT_W-1), which fits unsigned in AMT_W bits.
module bshf_decode
    import bshf_pkg::*;
#(
    parameter int AMT_W = 7
) (
    input  logic [2:0]       mode_i,
    input  logic [AMT_W-1:0] amt_i,
    output bshf_ctrl_t       ctrl_o,
    output logic [AMT_W-1:0] mag_o
);
    logic       neg;
    logic       named_left;
    bshf_mode_e mode_e;

    assign mode_e = bshf_mode_e'(mode_i);
    assign neg    = amt_i[AMT_W-1];

    // Magnitude of the signed count.
    always_comb begin
        mag_o = neg ? (~amt_i + AMT_W'(1)) : amt_i;
    end

    // Per-mode attributes and the direction after sign reversal.
    always_comb begin
        named_left       = 1'b0;
        ctrl_o           = '0;
        unique case (mode_e)
            MODE_ASL:     begin named_left = 1'b1; ctrl_o.arith = 1'b1; end
            MODE_LSL:     begin named_left = 1'b1; end
            MODE_ASR:     begin ctrl_o.arith = 1'b1; end
            MODE_LSR:     begin named_left = 1'b0; end
            MODE_ASL_SAT: begin named_left = 1'b1; ctrl_o.arith = 1'b1; end
            MODE_ASR_SAT: begin ctrl_o.arith = 1'b1; end
            MODE_ROL:     begin ctrl_o.rotate = 1'b1; end
            MODE_ROR:     begin ctrl_o.rotate = 1'b1; ctrl_o.rot_right = 1'b1; end
            default:      begin named_left = 1'b0; end
        endcase
        ctrl_o.go_left = named_left ^ neg;
        ctrl_o.sat_en  = ((mode_e == MODE_ASL_SAT) || (mode_e == MODE_ASR_SAT))
                         && (named_left ^ neg);
    end

endmodule

// File: rtl/bshf_linear.sv
// Linear barrel shift on a DATA_W vector already extended by the caller.
// A right shift is split into (magnitude-1) then 1 so that a magnitude equal
// to DATA_W still flushes completely to sign or zero bits.
module bshf_linear #(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 7
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic              go_left_i,
    input  logic              arith_i,
    input  logic [AMT_W-1:0]  mag_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] left_v;
    logic [DATA_W-1:0] step_v;
    logic [DATA_W-1:0] right_v;

    // Left shift fills with zeros; counts of DATA_W or more give zero.
    always_comb begin
        left_v = src_i << mag_i;
    end

    // Two-step right shift, sign or zero fill.
    always_comb begin
        step_v  = src_i;
        right_v = src_i;
        if (mag_i != '0) begin
            if (arith_i) begin
                step_v  = $signed(src_i) >>> (mag_i - AMT_W'(1));
                right_v = $signed(step_v) >>> 1;
            end else begin
                step_v  = src_i >> (mag_i - AMT_W'(1));
                right_v = step_v >> 1;
            end
        end
    end

    // Direction select.
    always_comb begin
        res_o = go_left_i ? left_v : right_v;
    end

endmodule

// File: rtl/bshf_satchk.sv
// Decides whether a left shift by mag_i of a signed operand of the selected
// width keeps its exact value, and supplies the clamp value from the
// original operand's sign. Assumes src_i is sign-extended to DATA_W in
// narrow mode.
module bshf_satchk #(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 7
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic              wide_i,
    input  logic [AMT_W-1:0]  mag_i,
    output logic              over_o,
    output logic [DATA_W-1:0] sat_val_o
);
    localparam int NARROW_W = DATA_W / 2;
    localparam int SH_W     = AMT_W + 1;
    localparam logic [DATA_W-1:0] WMAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] WMIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] NMAX = {{NARROW_W{1'b0}}, 1'b0, {(NARROW_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NMIN = {{NARROW_W{1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

    logic [SH_W-1:0]   width_v;
    logic [SH_W-1:0]   keep_sh;
    logic [DATA_W-1:0] top_v;
    logic              neg;

    assign neg     = src_i[DATA_W-1];
    assign width_v = wide_i ? SH_W'(DATA_W) : SH_W'(NARROW_W);

    // Fit test: the bits from the new sign position upward must all match.
    always_comb begin
        keep_sh = '0;
        top_v   = '0;
        if ({1'b0, mag_i} >= width_v) begin
            over_o = |src_i;
        end else begin
            keep_sh = width_v - SH_W'(1) - {1'b0, mag_i};
            top_v   = $signed(src_i) >>> keep_sh;
            over_o  = !((&top_v) || !(|top_v));
        end
    end

    // Clamp value chosen by the original operand's sign.
    always_comb begin
        if (wide_i) sat_val_o = neg ? WMIN : WMAX;
        else        sat_val_o = neg ? NMIN : NMAX;
    end

endmodule

// File: rtl/bshf_rotate.sv
// Rotator of width W with a count already reduced modulo W.
// A zero count passes the source through unchanged.
module bshf_rotate #(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W)
) (
    input  logic [W-1:0]     src_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             right_i,
    output logic [W-1:0]     res_o
);
    logic [CNT_W:0] comp;

    assign comp = (CNT_W+1)'(W) - {1'b0, cnt_i};

    // Combine the two opposite shifts.
    always_comb begin
        if (cnt_i == '0)  res_o = src_i;
        else if (right_i) res_o = (src_i >> cnt_i) | (src_i << comp);
        else              res_o = (src_i << cnt_i) | (src_i >> comp);
    end

endmodule

// File: rtl/bidir_shifter.sv
// Bidirectional saturating barrel shifter, top level. One register stage:
// an operation strobed with in_valid is presented the next cycle together
// with a one-cycle saturation pulse. Assumes DATA_W is even and a power of 2.
module bidir_shifter
    import bshf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int AMT_W  = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src,
    input  logic [AMT_W-1:0]  amt,
    input  logic [2:0]        mode,
    input  logic              wide,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              ovf
);
    localparam int NARROW_W = DATA_W / 2;

    bshf_ctrl_t        ctrl;
    logic [AMT_W-1:0]  mag;
    logic [DATA_W-1:0] src_ext;
    logic [DATA_W-1:0] lin_res;
    logic [DATA_W-1:0] sat_val;
    logic              over;
    logic              sat_hit;
    logic [DATA_W-1:0] rot_res [2];
    logic [DATA_W-1:0] res_raw;
    logic [DATA_W-1:0] res_next;

    bshf_decode #(.AMT_W(AMT_W)) u_decode (
        .mode_i (mode),
        .amt_i  (amt),
        .ctrl_o (ctrl),
        .mag_o  (mag)
    );

    // Operand extension to the datapath width for the selected size.
    always_comb begin
        if (wide)
            src_ext = src;
        else if (ctrl.arith)
            src_ext = {{NARROW_W{src[NARROW_W-1]}}, src[NARROW_W-1:0]};
        else
            src_ext = {{NARROW_W{1'b0}}, src[NARROW_W-1:0]};
    end

    bshf_linear #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_linear (
        .src_i     (src_ext),
        .go_left_i (ctrl.go_left),
        .arith_i   (ctrl.arith),
        .mag_i     (mag),
        .res_o     (lin_res)
    );

    bshf_satchk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_satchk (
        .src_i     (src_ext),
        .wide_i    (wide),
        .mag_i     (mag),
        .over_o    (over),
        .sat_val_o (sat_val)
    );

    // One rotator per supported width; index 0 narrow, index 1 wide.
    for (genvar g = 0; g < 2; g++) begin : g_rot
        localparam int RW = (g == 0) ? NARROW_W : DATA_W;
        localparam int CW = $clog2(RW);
        logic [RW-1:0] r_out;
        bshf_rotate #(.W(RW), .CNT_W(CW)) u_rot (
            .src_i   (src[RW-1:0]),
            .cnt_i   (amt[CW-1:0]),
            .right_i (ctrl.rot_right),
            .res_o   (r_out)
        );
        assign rot_res[g] = DATA_W'(r_out);
    end

    assign sat_hit = ctrl.sat_en && over;

    // Result selection among rotate, clamp and linear shift.
    always_comb begin
        if (ctrl.rotate)  res_raw = wide ? rot_res[1] : rot_res[0];
        else if (sat_hit) res_raw = sat_val;
        else              res_raw = lin_res;
    end

    // Narrow mode clears the upper half.
    always_comb begin
        res_next = wide ? res_raw : {{NARROW_W{1'b0}}, res_raw[NARROW_W-1:0]};
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ovf       <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            ovf       <= in_valid && sat_hit;
            if (in_valid) result <= res_next;
        end
    end

endmodule

// File: rtl/bshf_checker.sv
// Temporal properties of the shifter's port behaviour; bound to the top.
module bshf_checker #(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] src,
    input logic [AMT_W-1:0]  amt,
    input logic [2:0]        mode,
    input logic              wide,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              ovf
);
    localparam int NARROW_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] WMAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] WMIN = {1'b1, {(DATA_W-1){1'b0}}};

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    assert_clamp_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide) |=> (!ovf || result == WMAX || result == WMIN));

    assert_rotate_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && mode == 3'd6 && amt == '0) |=> (result == $past(src)));

    assert_narrow_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[DATA_W-1:NARROW_W] == '0));

    assert_ovf_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> out_valid);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != 3'd4 && mode != 3'd5) |=> !ovf);

endmodule

bind bidir_shifter bshf_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_bshf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src       (src),
    .amt       (amt),
    .mode      (mode),
    .wide      (wide),
    .out_valid (out_valid),
    .result    (result),
    .ovf       (ovf)
);

// File: tb/test_bidir_shifter.sv
module test_bidir_shifter;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 28;

    typedef struct packed {
        logic [2:0]  mode;
        logic        wide;
        logic [6:0]  amt;
        logic [63:0] src;
        logic [63:0] exp;
        logic        exp_ovf;
        logic [3:0]  req;
    } vec_t;

    // mode, wide, amt, src, expected result, expected ovf, requirement
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b1, 7'd4,   64'h0000_0000_0000_00F1, 64'h0000_0000_0000_0F10, 1'b0, 4'd3},  // R3
        '{3'd1, 1'b0, 7'd8,   64'hFFFF_FFFF_8000_00FF, 64'h0000_0000_0000_FF00, 1'b0, 4'd3},  // R3
        '{3'd0, 1'b1, 7'h7C,  64'h8000_0000_0000_0010, 64'hF800_0000_0000_0001, 1'b0, 4'd4},  // R4
        '{3'd1, 1'b1, 7'h7C,  64'h8000_0000_0000_0010, 64'h0800_0000_0000_0001, 1'b0, 4'd4},  // R4
        '{3'd0, 1'b1, 7'h40,  64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd4},  // R4
        '{3'd1, 1'b1, 7'h40,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b0, 4'd4},  // R4
        '{3'd2, 1'b0, 7'd31,  64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0, 4'd5},  // R5
        '{3'd2, 1'b0, 7'd40,  64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0, 4'd5},  // R5
        '{3'd3, 1'b1, 7'd63,  64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0, 4'd5},  // R5
        '{3'd2, 1'b1, 7'h78,  64'h0000_0000_0000_00AB, 64'h0000_0000_0000_AB00, 1'b0, 4'd6},  // R6
        '{3'd3, 1'b0, 7'h60,  64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1'b0, 4'd6},  // R6
        '{3'd4, 1'b0, 7'd4,   64'h0000_0000_0700_0000, 64'h0000_0000_7000_0000, 1'b0, 4'd7},  // R7
        '{3'd4, 1'b0, 7'd5,   64'h0000_0000_0700_0000, 64'h0000_0000_7FFF_FFFF, 1'b1, 4'd7},  // R7
        '{3'd4, 1'b0, 7'd1,   64'h0000_0000_C000_0000, 64'h0000_0000_8000_0000, 1'b0, 4'd7},  // R7
        '{3'd4, 1'b0, 7'd2,   64'h0000_0000_C000_0000, 64'h0000_0000_8000_0000, 1'b1, 4'd7},  // R7
        '{3'd4, 1'b1, 7'd63,  64'h0000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 4'd7},  // R7
        '{3'd4, 1'b0, 7'd40,  64'h0000_0000_0000_0001, 64'h0000_0000_7FFF_FFFF, 1'b1, 4'd8},  // R8
        '{3'd4, 1'b1, 7'd63,  64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0, 4'd8},  // R8
        '{3'd5, 1'b0, 7'h7D,  64'h0000_0000_F000_0001, 64'h0000_0000_8000_0008, 1'b0, 4'd7},  // R7
        '{3'd5, 1'b1, 7'h40,  64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, 4'd7},  // R7
        '{3'd5, 1'b1, 7'd5,   64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 4'd5},  // R5
        '{3'd4, 1'b1, 7'h7F,  64'h8000_0000_0000_0001, 64'hC000_0000_0000_0000, 1'b0, 4'd4},  // R4
        '{3'd6, 1'b1, 7'd0,   64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0, 4'd9},  // R9
        '{3'd6, 1'b1, 7'd4,   64'h0123_4567_89AB_CDEF, 64'h1234_5678_9ABC_DEF0, 1'b0, 4'd9},  // R9
        '{3'd7, 1'b0, 7'd8,   64'h0000_0000_1234_5678, 64'h0000_0000_7812_3456, 1'b0, 4'd9},  // R9
        '{3'd6, 1'b0, 7'h78,  64'h0000_0000_1234_5678, 64'h0000_0000_7812_3456, 1'b0, 4'd9},  // R9
        '{3'd6, 1'b0, 7'd32,  64'h0000_0000_1234_5678, 64'h0000_0000_1234_5678, 1'b0, 4'd9},  // R9
        '{3'd2, 1'b0, 7'd4,   64'hABCD_0000_7000_0000, 64'h0000_0000_0700_0000, 1'b0, 4'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] src;
    logic [6:0]  amt;
    logic [2:0]  mode;
    logic        wide;
    logic        out_valid;
    logic [63:0] result;
    logic        ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_shifter i_bidir_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .src       (src),
        .amt       (amt),
        .mode      (mode),
        .wide      (wide),
        .out_valid (out_valid),
        .result    (result),
        .ovf       (ovf)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive an operation at the falling edge, sample after the next rising edge.
    task automatic run_op(input logic [2:0] m, input logic w, input logic [6:0] a,
                          input logic [63:0] s);
        @(negedge clk);
        in_valid = 1'b1; mode = m; wide = w; amt = a; src = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset clears outputs even with an active saturating request.
        rst_n = 1'b0; in_valid = 1'b1; mode = 3'd4; wide = 1'b1;
        amt = 7'd63; src = 64'h1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 ovf", {63'd0, ovf}, 64'd0);
        check("R1 result", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;

        // Table walk; each result lands one edge after the drive.
        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i].mode, VECS[i].wide, VECS[i].amt, VECS[i].src);
            check($sformatf("R%0d result vec%0d", VECS[i].req, i), result, VECS[i].exp);
            check($sformatf("R11 ovf vec%0d", i), {63'd0, ovf}, {63'd0, VECS[i].exp_ovf});
            check($sformatf("R2 out_valid vec%0d", i), {63'd0, out_valid}, 64'd1);
        end

        // R11 and R2: a clamp pulse lasts one cycle; idle cycle holds result.
        run_op(3'd4, 1'b1, 7'd63, 64'h1);
        check("R11 pulse high", {63'd0, ovf}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0; src = 64'h5555_5555_5555_5555; mode = 3'd1; amt = 7'd1;
        @(posedge clk);
        #1;
        check("R11 pulse ends", {63'd0, ovf}, 64'd0);
        check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R2 idle holds result", result, 64'h7FFF_FFFF_FFFF_FFFF);

        // R10: narrow saturation ignores a nonzero upper source half.
        run_op(3'd4, 1'b0, 7'd3, 64'hFFFF_0000_0000_0001);
        check("R10 narrow upper ignored", result, 64'h0000_0000_0000_0008);
        check("R10 narrow no clamp", {63'd0, ovf}, 64'd0);

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule